// File: doc/BRIEF.md
# Translation Lookaside Buffer with Fault Classification

This block translates virtual addresses to physical addresses through two small fully associative lookup arrays: one serves instruction fetches, the other serves data loads and stores. Every lookup compares the virtual page number and the current process identifier against every entry in the array. Each entry carries its own page size, so the compare is masked per entry. Each lookup produces exactly one of four outcomes: a hit with a physical address, a miss, a multiple-hit fault, or a protection violation. The multiple-hit fault is fatal, and the logic downstream treats it as a reset-class event.

When a lookup faults, the block records the faulting virtual address and the page and process identity in two capture registers. One bit of the capture records which side raised the fault. Fault handling software refills an array by presenting a staged entry on the write port. The entry lands in the slot chosen by that side's replacement pointer. Hardware advances the pointer after each write, and software may load it directly beforehand.

Lookup requests and responses on each side use valid/ready handshakes. A request is taken on a cycle where valid and ready are both high. Its response appears one cycle later and is held until it is taken. While a response is waiting, the request side is back-pressured. The write port, the pointer load, the process identifier and the privilege input are plain control pins.

Top module: `tlbx_mmu`

## Requirements
- R1: A request is accepted when req_valid and req_ready are both high. req_ready is high when no response is held or when the held response is taken in the same cycle. The response is valid in the cycle after acceptance, and its fault code, address and attributes hold steady while rsp_valid is high and rsp_ready is low.
- R2: A lookup that matches exactly one entry, with that entry valid and the access permitted, returns fault code 0. The physical address is built from three parts: the entry's frame bits above the page boundary, the virtual page bits below it, and VA[9:0]. Size code 0, 1, 2 and 3 give pages of 1 KB, 4 KB, 64 KB and 1 MB. The tag compare ignores the virtual page bits below the entry's page boundary.
- R3: An entry whose global bit is set matches any process identifier. Otherwise the entry's identifier must equal cur_asid.
- R4: Fault code 1 (miss) is returned when no entry matches, or when the single matching entry has its valid bit clear. After reset every entry is invalid, and entry k carries tag k with identifier 0.
- R5: Fault code 2 (multiple hit) is returned when two or more entries match, whatever their valid bits. This code takes priority over miss and protection.
- R6: Fault code 3 (protection) is returned on a single valid match under any of three conditions. First, user_mode=1 and permission bit 2 (user access) is clear. Second, a data write is made with permission bit 1 (write) clear. Third, an instruction fetch is made with permission bit 0 (execute) clear.
- R7: A data write that hits an entry whose dirty bit is clear returns fault code 3.
- R8: On a hit, d_rsp_attr returns {C,B,W} of the entry and i_rsp_cache returns C. Instruction entries store no B, W or D.
- R9: A faulting lookup loads exc_addr with its virtual address and loads exc_hi with {VA[31:10], 1'b0, side, asid}, where side is 1 for an instruction fault. If both sides fault in the same cycle, the data fault is captured. Lookups that hit leave both registers unchanged.
- R10: A write (wr_valid) stores the entry into the slot of the chosen side's pointer. That pointer then advances by one, modulo ENTRIES. The other side's pointer is unchanged. wr_ctl bits are: 10 V, 9 C, 8 G, 7 B, 6:4 AP, 3:2 SZ, 1 W, 0 D.
- R11: ptr_set_valid loads the chosen side's pointer with ptr_set_val. A write in the same cycle on the same side uses the old pointer, and the loaded value replaces the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | 8 | Current process identifier |
| user_mode | input | 1 | 1 when the access is made in user mode |
| i_req_valid | input | 1 | Instruction lookup request valid |
| i_req_ready | output | 1 | Instruction side can take a request |
| i_req_va | input | 32 | Instruction fetch virtual address |
| i_rsp_valid | output | 1 | Instruction response valid |
| i_rsp_ready | input | 1 | Instruction response taken |
| i_rsp_fault | output | 2 | 0 hit, 1 miss, 2 multiple hit, 3 protection |
| i_rsp_pa | output | 32 | Instruction physical address |
| i_rsp_cache | output | 1 | Cacheable attribute of the hit entry |
| d_req_valid | input | 1 | Data lookup request valid |
| d_req_ready | output | 1 | Data side can take a request |
| d_req_va | input | 32 | Data virtual address |
| d_req_write | input | 1 | 1 for a store |
| d_rsp_valid | output | 1 | Data response valid |
| d_rsp_ready | input | 1 | Data response taken |
| d_rsp_fault | output | 2 | Fault code, same encoding as the instruction side |
| d_rsp_pa | output | 32 | Data physical address |
| d_rsp_attr | output | 3 | {C,B,W} of the hit entry |
| wr_valid | input | 1 | Write the staged entry |
| wr_data_side | input | 1 | 1 selects the data array, 0 the instruction array |
| wr_vpn | input | 22 | Staged entry virtual page number |
| wr_asid | input | 8 | Staged entry process identifier |
| wr_pfn | input | 22 | Staged entry frame number |
| wr_ctl | input | 11 | Staged entry control bits, layout in R10 |
| ptr_set_valid | input | 1 | Load a replacement pointer |
| ptr_set_data | input | 1 | 1 loads the data pointer, 0 the instruction pointer |
| ptr_set_val | input | 3 | Value to load |
| i_ptr | output | 3 | Instruction replacement pointer |
| d_ptr | output | 3 | Data replacement pointer |
| exc_addr | output | 32 | Captured faulting virtual address |
| exc_hi | output | 32 | Captured page, side and identifier |

## Verification
The bench builds the block with the default of eight entries per side. With that setting, the modulo wrap of the data pointer from 7 back to 0 is reached after a handful of writes. Reset-state slots with their distinct tags stay in the array next to software-written ones. Eight slots are also enough to place two overlapping entries of different page sizes, an invalid entry and a global 1 MB entry side by side. Every fault class and the per-entry size masking can therefore be reached within one small array.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 10;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 22;
  localparam int ASID_W = 8;
  localparam int CTL_W  = 11;

  // control-word bit positions for the staged entry
  localparam int CB_V  = 10;
  localparam int CB_C  = 9;
  localparam int CB_G  = 8;
  localparam int CB_B  = 7;
  localparam int CB_AP = 4;
  localparam int CB_SZ = 2;
  localparam int CB_W  = 1;
  localparam int CB_D  = 0;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_MULTI = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              v;
    logic [PFN_W-1:0]  pfn;
    logic              c;
    logic              g;
    logic              b;
    logic [2:0]        ap;
    logic [1:0]        sz;
    logic              w;
    logic              d;
  } entry_t;

  // page-number bits that lie inside the page for each size code
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = VPN_W'(0);
      2'd1:    size_mask = VPN_W'(10'h003);
      2'd2:    size_mask = VPN_W'(10'h03F);
      default: size_mask = VPN_W'(10'h3FF);
    endcase
  endfunction
endpackage

// File: rtl/tlbx_entries.sv
module tlbx_entries
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter bit IS_DATA = 1'b1,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  entry_t           wentry,
  output entry_t           ents [ENTRIES]
);
  entry_t stored;

  generate
    if (IS_DATA) begin : g_full
      assign stored = wentry;
    end else begin : g_subset
      always_comb begin
        stored   = wentry;
        stored.b = 1'b0;
        stored.w = 1'b0;
        stored.d = 1'b0;
      end
    end
  endgenerate

  for (genvar k = 0; k < ENTRIES; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[k]     <= '0;
        ents[k].vpn <= VPN_W'(k);
      end else if (we && widx == IDX_W'(k)) begin
        ents[k] <= stored;
      end
    end
  end
endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter bit IS_DATA = 1'b1
) (
  input  entry_t              ents [ENTRIES],
  input  logic [VPN_W-1:0]    vpn,
  input  logic [ASID_W-1:0]   asid,
  input  logic                user,
  input  logic                write,
  output fault_e              fault,
  output logic [PFN_W-1:0]    frame,
  output logic [2:0]          attr
);
  logic [ENTRIES-1:0] match;
  entry_t             sel;
  logic               multi, any, perm_ok;
  logic [VPN_W-1:0]   smask;

  always_comb begin
    match = '0;
    sel   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      match[k] = (((ents[k].vpn ^ vpn) & ~size_mask(ents[k].sz)) == '0) &&
                 (ents[k].g || ents[k].asid == asid);
    end
    for (int k = 0; k < ENTRIES; k++) begin
      if (match[k]) sel = sel | ents[k];
    end
  end

  assign any   = |match;
  assign multi = |(match & (match - ENTRIES'(1)));
  assign smask = size_mask(sel.sz);

  generate
    if (IS_DATA) begin : g_dperm
      assign perm_ok = !(user && !sel.ap[2]) && !(write && (!sel.ap[1] || !sel.d));
      assign attr    = {sel.c, sel.b, sel.w};
    end else begin : g_iperm
      assign perm_ok = !(user && !sel.ap[2]) && sel.ap[0] && !(write && sel.d);
      assign attr    = {sel.c, sel.b & sel.w, 1'b0};
    end
  endgenerate

  always_comb begin
    if (multi)               fault = FLT_MULTI;
    else if (!any || !sel.v) fault = FLT_MISS;
    else if (!perm_ok)       fault = FLT_PROT;
    else                     fault = FLT_NONE;
  end

  assign frame = (sel.pfn & ~PFN_W'(smask)) | (PFN_W'(vpn) & PFN_W'(smask));
endmodule

// File: rtl/tlbx_rptr.sv
module tlbx_rptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= (ptr == IDX_W'(ENTRIES-1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlbx_side.sv
module tlbx_side
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter bit IS_DATA = 1'b1,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] asid,
  input  logic              user,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output fault_e            rsp_fault,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_attr,
  input  logic              wr_en,
  input  entry_t            wr_entry,
  input  logic              ptr_load,
  input  logic [IDX_W-1:0]  ptr_val,
  output logic [IDX_W-1:0]  ptr,
  output logic              acc,
  output fault_e            acc_fault
);
  entry_t            ents [ENTRIES];
  logic [PFN_W-1:0]  frame;
  logic [2:0]        attr;

  tlbx_entries #(.ENTRIES(ENTRIES), .IS_DATA(IS_DATA)) u_ents (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(ptr),
    .wentry(wr_entry), .ents(ents)
  );

  tlbx_lookup #(.ENTRIES(ENTRIES), .IS_DATA(IS_DATA)) u_look (
    .ents(ents), .vpn(req_va[VA_W-1:OFF_W]), .asid(asid), .user(user),
    .write(req_write), .fault(acc_fault), .frame(frame), .attr(attr)
  );

  tlbx_rptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_val),
    .step(wr_en), .ptr(ptr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_fault <= acc_fault;
      rsp_pa    <= {frame, req_va[OFF_W-1:0]};
      rsp_attr  <= attr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbx_mmu.sv
module tlbx_mmu
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              user_mode,
  input  logic              i_req_valid,
  output logic              i_req_ready,
  input  logic [VA_W-1:0]   i_req_va,
  output logic              i_rsp_valid,
  input  logic              i_rsp_ready,
  output logic [1:0]        i_rsp_fault,
  output logic [VA_W-1:0]   i_rsp_pa,
  output logic              i_rsp_cache,
  input  logic              d_req_valid,
  output logic              d_req_ready,
  input  logic [VA_W-1:0]   d_req_va,
  input  logic              d_req_write,
  output logic              d_rsp_valid,
  input  logic              d_rsp_ready,
  output logic [1:0]        d_rsp_fault,
  output logic [VA_W-1:0]   d_rsp_pa,
  output logic [2:0]        d_rsp_attr,
  input  logic              wr_valid,
  input  logic              wr_data_side,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [CTL_W-1:0]  wr_ctl,
  input  logic              ptr_set_valid,
  input  logic              ptr_set_data,
  input  logic [IDX_W-1:0]  ptr_set_val,
  output logic [IDX_W-1:0]  i_ptr,
  output logic [IDX_W-1:0]  d_ptr,
  output logic [VA_W-1:0]   exc_addr,
  output logic [31:0]       exc_hi
);
  entry_t            staged;
  fault_e            i_flt, d_flt, i_acc_flt, d_acc_flt;
  logic              i_acc, d_acc;
  logic [2:0]        i_attr;
  logic [VPN_W-1:0]  exc_vpn;
  logic [ASID_W-1:0] exc_asid;
  logic              exc_instr;

  always_comb begin
    staged      = '0;
    staged.vpn  = wr_vpn;
    staged.asid = wr_asid;
    staged.pfn  = wr_pfn;
    staged.v    = wr_ctl[CB_V];
    staged.c    = wr_ctl[CB_C];
    staged.g    = wr_ctl[CB_G];
    staged.b    = wr_ctl[CB_B];
    staged.ap   = wr_ctl[CB_AP +: 3];
    staged.sz   = wr_ctl[CB_SZ +: 2];
    staged.w    = wr_ctl[CB_W];
    staged.d    = wr_ctl[CB_D];
  end

  tlbx_side #(.ENTRIES(ENTRIES), .IS_DATA(1'b0)) u_iside (
    .clk(clk), .rst_n(rst_n), .asid(cur_asid), .user(user_mode),
    .req_valid(i_req_valid), .req_ready(i_req_ready), .req_va(i_req_va),
    .req_write(1'b0), .rsp_valid(i_rsp_valid), .rsp_ready(i_rsp_ready),
    .rsp_fault(i_flt), .rsp_pa(i_rsp_pa), .rsp_attr(i_attr),
    .wr_en(wr_valid && !wr_data_side), .wr_entry(staged),
    .ptr_load(ptr_set_valid && !ptr_set_data), .ptr_val(ptr_set_val),
    .ptr(i_ptr), .acc(i_acc), .acc_fault(i_acc_flt)
  );

  tlbx_side #(.ENTRIES(ENTRIES), .IS_DATA(1'b1)) u_dside (
    .clk(clk), .rst_n(rst_n), .asid(cur_asid), .user(user_mode),
    .req_valid(d_req_valid), .req_ready(d_req_ready), .req_va(d_req_va),
    .req_write(d_req_write), .rsp_valid(d_rsp_valid), .rsp_ready(d_rsp_ready),
    .rsp_fault(d_flt), .rsp_pa(d_rsp_pa), .rsp_attr(d_rsp_attr),
    .wr_en(wr_valid && wr_data_side), .wr_entry(staged),
    .ptr_load(ptr_set_valid && ptr_set_data), .ptr_val(ptr_set_val),
    .ptr(d_ptr), .acc(d_acc), .acc_fault(d_acc_flt)
  );

  assign i_rsp_fault = i_flt;
  assign d_rsp_fault = d_flt;
  assign i_rsp_cache = i_attr[2] | (i_attr[1] & i_attr[0]);

  // capture: data side wins a same-cycle tie
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_addr  <= '0;
      exc_vpn   <= '0;
      exc_asid  <= '0;
      exc_instr <= 1'b0;
    end else if (d_acc && d_acc_flt != FLT_NONE) begin
      exc_addr  <= d_req_va;
      exc_vpn   <= d_req_va[VA_W-1:OFF_W];
      exc_asid  <= cur_asid;
      exc_instr <= 1'b0;
    end else if (i_acc && i_acc_flt != FLT_NONE) begin
      exc_addr  <= i_req_va;
      exc_vpn   <= i_req_va[VA_W-1:OFF_W];
      exc_asid  <= cur_asid;
      exc_instr <= 1'b1;
    end
  end

  assign exc_hi = {exc_vpn, 1'b0, exc_instr, exc_asid};
endmodule

// File: rtl/tlbx_mmu_chk.sv
module tlbx_mmu_chk #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_req_valid,
  input logic             i_req_ready,
  input logic             i_rsp_valid,
  input logic             i_rsp_ready,
  input logic [1:0]       i_rsp_fault,
  input logic [31:0]      i_rsp_pa,
  input logic             d_req_valid,
  input logic             d_req_ready,
  input logic [31:0]      d_req_va,
  input logic             d_rsp_valid,
  input logic             d_rsp_ready,
  input logic [1:0]       d_rsp_fault,
  input logic [31:0]      d_rsp_pa,
  input logic             wr_valid,
  input logic             wr_data_side,
  input logic             ptr_set_valid,
  input logic             ptr_set_data,
  input logic [IDX_W-1:0] ptr_set_val,
  input logic [IDX_W-1:0] d_ptr,
  input logic [31:0]      exc_addr,
  input logic [31:0]      exc_hi
);
  logic [IDX_W-1:0] d_next;
  always_comb d_next = (d_ptr == IDX_W'(ENTRIES-1)) ? '0 : d_ptr + 1'b1;

  AST_D_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    d_rsp_valid && !d_rsp_ready |=> d_rsp_valid && $stable(d_rsp_fault) && $stable(d_rsp_pa)); // R1
  AST_I_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    i_rsp_valid && !i_rsp_ready |=> i_rsp_valid && $stable(i_rsp_fault) && $stable(i_rsp_pa)); // R1
  AST_D_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid && d_req_ready |=> d_rsp_valid); // R1
  AST_I_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid && i_req_ready |=> i_rsp_valid); // R1
  AST_D_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_data_side && !(ptr_set_valid && ptr_set_data) |=> d_ptr == $past(d_next)); // R10
  AST_D_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_set_valid && ptr_set_data |=> d_ptr == $past(ptr_set_val)); // R11
  AST_D_EXC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid && d_req_ready |=> d_rsp_fault == 2'd0 || (exc_addr == $past(d_req_va) && !exc_hi[8])); // R9
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_req_valid && d_req_ready) && !(i_req_valid && i_req_ready) |=> $stable(exc_addr) && $stable(exc_hi)); // R9
endmodule

bind tlbx_mmu tlbx_mmu_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tlbx_mmu_bench.sv
`timescale 1ns/1ps
module tlbx_mmu_bench;
  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        user;
    logic        wr;
    logic [1:0]  fault;
    logic [31:0] pa;
    logic [2:0]  attr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0123, 8'd5, 1'b1, 1'b0, 2'd0, 32'h0AAA_A923, 3'b101}, // R2 1K hit
    '{32'h0040_0123, 8'd6, 1'b0, 1'b0, 2'd1, 32'h0, 3'b000},         // R3 asid mismatch
    '{32'h0040_0123, 8'd5, 1'b1, 1'b1, 2'd0, 32'h0AAA_A923, 3'b101}, // R6 user write ok
    '{32'h100A_BCDE, 8'd9, 1'b0, 1'b0, 2'd0, 32'h0FFA_BCDE, 3'b010}, // R3 global 1M
    '{32'h100A_BCDE, 8'd9, 1'b1, 1'b0, 2'd3, 32'h0, 3'b000},         // R6 user denied
    '{32'h100A_BCDE, 8'd2, 1'b0, 1'b1, 2'd0, 32'h0FFA_BCDE, 3'b010}, // R6 priv write
    '{32'h0080_0040, 8'd5, 1'b0, 1'b0, 2'd1, 32'h0, 3'b000},         // R4 invalid entry
    '{32'h00C0_0010, 8'd5, 1'b0, 1'b0, 2'd2, 32'h0, 3'b000},         // R5 overlap
    '{32'h00C0_5000, 8'd5, 1'b0, 1'b0, 2'd0, 32'h0040_5000, 3'b110}, // R2 64K hit
    '{32'h00C0_5000, 8'd5, 1'b0, 1'b1, 2'd3, 32'h0, 3'b000},         // R7 clean page
    '{32'h0100_0010, 8'd5, 1'b0, 1'b0, 2'd1, 32'h0, 3'b000},         // R3 non-global
    '{32'h0100_0010, 8'd7, 1'b0, 1'b0, 2'd0, 32'h0000_2010, 3'b000}, // R3 own asid
    '{32'h7FFF_0000, 8'd5, 1'b0, 1'b0, 2'd1, 32'h0, 3'b000}          // R4 unmapped
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cur_asid = '0;
  logic user_mode = 1'b0;
  logic i_req_valid = 1'b0, i_rsp_ready = 1'b1;
  logic [31:0] i_req_va = '0;
  logic d_req_valid = 1'b0, d_req_write = 1'b0, d_rsp_ready = 1'b1;
  logic [31:0] d_req_va = '0;
  logic wr_valid = 1'b0, wr_data_side = 1'b0;
  logic [21:0] wr_vpn = '0, wr_pfn = '0;
  logic [7:0] wr_asid = '0;
  logic [10:0] wr_ctl = '0;
  logic ptr_set_valid = 1'b0, ptr_set_data = 1'b0;
  logic [2:0] ptr_set_val = '0;
  logic i_req_ready, i_rsp_valid, i_rsp_cache, d_req_ready, d_rsp_valid;
  logic [1:0] i_rsp_fault, d_rsp_fault;
  logic [31:0] i_rsp_pa, d_rsp_pa, exc_addr, exc_hi;
  logic [2:0] d_rsp_attr, i_ptr, d_ptr;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tlbx_mmu u_tlbx_mmu (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] ctl(input logic v, c, g, b, input logic [2:0] ap,
                                      input logic [1:0] sz, input logic w, d);
    return {v, c, g, b, ap, sz, w, d};
  endfunction

  task automatic put(input logic side, input logic [31:0] va, input logic [7:0] asid,
                     input logic [21:0] pfn, input logic [10:0] c);
    @(negedge clk);
    wr_valid = 1'b1; wr_data_side = side; wr_vpn = va[31:10];
    wr_asid = asid; wr_pfn = pfn; wr_ctl = c;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic dlook(input logic [31:0] va, input logic [7:0] asid,
                       input logic user, input logic wr);
    @(negedge clk);
    d_req_valid = 1'b1; d_req_va = va; cur_asid = asid;
    user_mode = user; d_req_write = wr;
    @(negedge clk);
    d_req_valid = 1'b0;
  endtask

  task automatic ilook(input logic [31:0] va, input logic [7:0] asid, input logic user);
    @(negedge clk);
    i_req_valid = 1'b1; i_req_va = va; cur_asid = asid; user_mode = user;
    @(negedge clk);
    i_req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] keep_a, keep_h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R10 reset d_ptr", 32'(d_ptr), 32'd0);
    chk("R10 reset i_ptr", 32'(i_ptr), 32'd0);
    chk("R1 reset rsp idle", 32'(d_rsp_valid), 32'd0);
    chk("R1 reset ready", 32'(d_req_ready), 32'd1);
    chk("R9 reset exc_hi", exc_hi, 32'd0);
    dlook(32'h0000_0C00, 8'd0, 1'b0, 1'b0);
    chk("R4 reset slot tag miss", 32'(d_rsp_fault), 32'd1);
    chk("R9 reset miss capture", exc_hi, 32'h0000_0C00);

    // data array setup, slots 0..5
    put(1'b1, 32'h0040_0000, 8'd5, 22'h2AAAA, ctl(1,1,0,0,3'b111,2'd0,1,1));
    put(1'b1, 32'h1000_0000, 8'd0, 22'h3FC00, ctl(1,0,1,1,3'b010,2'd3,0,1));
    put(1'b1, 32'h0080_0000, 8'd5, 22'h00003, ctl(0,0,0,0,3'b111,2'd0,0,1));
    put(1'b1, 32'h00C0_0000, 8'd5, 22'h00004, ctl(1,1,0,0,3'b111,2'd1,0,1));
    put(1'b1, 32'h00C0_0000, 8'd5, 22'h01000, ctl(1,1,0,1,3'b111,2'd2,0,0));
    put(1'b1, 32'h0100_0000, 8'd7, 22'h00008, ctl(1,0,0,0,3'b111,2'd0,0,1));
    chk("R10 d_ptr after six writes", 32'(d_ptr), 32'd6);
    chk("R10 i_ptr untouched", 32'(i_ptr), 32'd0);

    for (int n = 0; n < NV; n++) begin
      keep_a = exc_addr; keep_h = exc_hi;
      dlook(VECS[n].va, VECS[n].asid, VECS[n].user, VECS[n].wr);
      chk($sformatf("R1/R2-R7 vec%0d valid", n), 32'(d_rsp_valid), 32'd1);
      chk($sformatf("R2-R7 vec%0d fault", n), 32'(d_rsp_fault), 32'(VECS[n].fault));
      if (VECS[n].fault == 2'd0) begin
        chk($sformatf("R2 vec%0d pa", n), d_rsp_pa, VECS[n].pa);
        chk($sformatf("R8 vec%0d attr", n), 32'(d_rsp_attr), 32'(VECS[n].attr));
        chk($sformatf("R9 vec%0d hit keeps addr", n), exc_addr, keep_a);
        chk($sformatf("R9 vec%0d hit keeps hi", n), exc_hi, keep_h);
      end else begin
        chk($sformatf("R9 vec%0d exc_addr", n), exc_addr, VECS[n].va);
        chk($sformatf("R9 vec%0d exc_hi", n), exc_hi,
            {VECS[n].va[31:10], 2'b00, VECS[n].asid});
      end
    end

    // R5: invalid and valid entries with the same tag
    put(1'b1, 32'h0080_0000, 8'd5, 22'h00001, ctl(1,0,0,0,3'b111,2'd0,0,1));
    chk("R10 d_ptr 7", 32'(d_ptr), 32'd7);
    dlook(32'h0080_0040, 8'd5, 1'b0, 1'b0);
    chk("R5 multi regardless of valid", 32'(d_rsp_fault), 32'd2);

    // R11: load and write in one cycle
    @(negedge clk);
    ptr_set_valid = 1'b1; ptr_set_data = 1'b1; ptr_set_val = 3'd2;
    wr_valid = 1'b1; wr_data_side = 1'b1; wr_vpn = 22'(32'h0200_0000 >> 10);
    wr_asid = 8'd5; wr_pfn = 22'h55; wr_ctl = ctl(1,0,0,0,3'b111,2'd0,0,1);
    @(negedge clk);
    ptr_set_valid = 1'b0; wr_valid = 1'b0;
    chk("R11 load wins over step", 32'(d_ptr), 32'd2);
    dlook(32'h0200_0008, 8'd5, 1'b0, 1'b0);
    chk("R11 write used old pointer", 32'(d_rsp_fault), 32'd0);
    chk("R11 written pa", d_rsp_pa, 32'h0001_5408);

    // R10 wrap: load 7 then write
    @(negedge clk);
    ptr_set_valid = 1'b1; ptr_set_data = 1'b1; ptr_set_val = 3'd7;
    @(negedge clk);
    ptr_set_valid = 1'b0;
    chk("R11 load alone", 32'(d_ptr), 32'd7);
    put(1'b1, 32'h0300_0000, 8'd5, 22'h00066, ctl(1,0,0,0,3'b111,2'd0,0,1));
    chk("R10 wrap to zero", 32'(d_ptr), 32'd0);
    dlook(32'h0200_0008, 8'd5, 1'b0, 1'b0);
    chk("R10 slot 7 overwritten", 32'(d_rsp_fault), 32'd1);
    dlook(32'h0300_0004, 8'd5, 1'b0, 1'b0);
    chk("R10 new slot 7 hit", d_rsp_pa, 32'h0001_9804);

    // instruction side
    put(1'b0, 32'h0040_0000, 8'd5, 22'h00100, ctl(1,0,0,0,3'b110,2'd0,0,1));
    put(1'b0, 32'h0050_0000, 8'd0, 22'h00204, ctl(1,1,1,0,3'b001,2'd1,0,0));
    chk("R10 i_ptr two", 32'(i_ptr), 32'd2);
    chk("R10 d_ptr unchanged", 32'(d_ptr), 32'd0);
    ilook(32'h0040_0010, 8'd5, 1'b0);
    chk("R6 fetch without execute", 32'(i_rsp_fault), 32'd3);
    chk("R9 instr exc_addr", exc_addr, 32'h0040_0010);
    chk("R9 instr exc_hi", exc_hi, 32'h0040_0105);
    ilook(32'h0050_0A44, 8'd3, 1'b0);
    chk("R2 fetch 4K hit", 32'(i_rsp_fault), 32'd0);
    chk("R2 fetch 4K pa", i_rsp_pa, 32'h0008_1A44);
    chk("R8 fetch cacheable", 32'(i_rsp_cache), 32'd1);
    ilook(32'h0050_0A44, 8'd3, 1'b1);
    chk("R6 user fetch denied", 32'(i_rsp_fault), 32'd3);

    // R9: both sides fault together
    @(negedge clk);
    i_req_valid = 1'b1; i_req_va = 32'h0090_0000;
    d_req_valid = 1'b1; d_req_va = 32'h00A0_0004; d_req_write = 1'b0;
    cur_asid = 8'd5; user_mode = 1'b0;
    @(negedge clk);
    i_req_valid = 1'b0; d_req_valid = 1'b0;
    chk("R9 tie instr fault seen", 32'(i_rsp_fault), 32'd1);
    chk("R9 tie data captured", exc_addr, 32'h00A0_0004);
    chk("R9 tie side bit", exc_hi, 32'h00A0_0005);

    // R1: back-pressure
    @(negedge clk);
    d_rsp_ready = 1'b0;
    dlook(32'h0040_0123, 8'd5, 1'b0, 1'b0);
    chk("R1 rsp valid under stall", 32'(d_rsp_valid), 32'd1);
    chk("R1 ready low under stall", 32'(d_req_ready), 32'd0);
    @(negedge clk);
    chk("R1 rsp held", 32'(d_rsp_valid), 32'd1);
    chk("R1 pa held", d_rsp_pa, 32'h0AAA_A923);
    d_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R1 rsp drained", 32'(d_rsp_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule